// File: doc/BRIEF.md
# External Data Space Access Router

This block sits between an 8-bit core's external-data load/store path and everything that can answer it. A small window at the top of the 64 KiB external data map is implemented on chip. The range F700H–F7FFH goes to a peripheral and F800H–FFFFH goes to a RAM. The block decides, one access at a time and with no added latency, whether the access is served internally or goes out on the multiplexed external bus. It also drives the matching selects, strobes and port output enables, and muxes the read data back to the core.

Behaviour is set by one special function register at SFR address B1H. Bit 0 turns the internal window off. It resets to 1, so after reset everything goes to the external bus. Clearing it needs an unlock write just before. Bit 1 turns on a trace mode. In trace mode, internal accesses also pulse the external strobes and drive the address and the transferred data onto the port pins. An observer on the board can then watch internal traffic.

Top module: `xdata_router`

## Requirements
- R1: After reset the control register at SFR address B1H reads A9H: bit 0 (window off) is 1 and bit 1 (trace) is 0. All internal selects and all external strobes are low while no access is requested.
- R2: While bit 0 is 1, every access is external. The read strobe `ext_rd` follows a read and the write strobe `ext_wr` follows a write. `port_addr_oe` is high, `port_data_oe` follows a write, neither internal select is high, and read data comes from `ext_rdata`.
- R3: An access with an address below F700H is external in the same way whatever the control bits hold.
- R4: While bit 0 is 0, an access in F700H–F7FFH raises `per_sel` and an access in F800H–FFFFH raises `ram_sel`. `int_we` follows the access direction. Read data comes from `per_rdata` or `ram_rdata` respectively.
- R5: While bit 0 is 0 and bit 1 is 0, an internal access keeps `ext_rd`, `ext_wr`, `port_addr_oe` and `port_data_oe` all low.
- R6: While bit 0 is 0 and bit 1 is 1, an internal access asserts the strobe for its direction, `port_addr_oe` and `port_data_oe`. `port_addr` carries the address. `port_dout` carries the write data on a write and the internal read data on a read.
- R7: A write to B1H may clear bit 0 only if the write on the directly preceding clock cycle wrote the key 5AH to B1H. Otherwise bit 0 keeps its value while the other writable bits still update. A key write itself changes no bit.
- R8: A write to B1H with bit 0 set sets bit 0 at once, with no key.
- R9: Bits 7 and 3 always read 1 and ignore writes. Bits 6, 5, 4, 2 and 1 take the written value. A read of any SFR address other than B1H returns 00H.
- R10: A write to any other SFR address leaves the control register unchanged. Such a write also cancels a pending key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | External-data access this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Access address |
| acc_wdata | input | 8 | Write data from core |
| acc_rdata | output | 8 | Read data to core |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data |
| ram_rdata | input | 8 | Read data from internal RAM |
| per_rdata | input | 8 | Read data from internal peripheral |
| ext_rdata | input | 8 | Read data from external port |
| ram_sel | output | 1 | Internal RAM select |
| per_sel | output | 1 | Internal peripheral select |
| int_we | output | 1 | Write enable to internal targets |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| port_addr_oe | output | 1 | Port address drive enable |
| port_data_oe | output | 1 | Port data drive enable |
| port_addr | output | 16 | Address to port pads |
| port_dout | output | 8 | Data to port pads |

## Verification
The only state is the two-bit control pair and the one-cycle unlock flag. A wrong value in either shows up on the very next access, as a select on the wrong side or a strobe that is missing or spurious. The control register also shows it on an SFR read in the same cycle. The bench sweeps every high address byte in all four control states and both directions. A corrupted unlock flag is caught by key sequences with and without a gap and with an intervening foreign write, each followed by a readback.

// File: rtl/xdr_pkg.sv
package xdr_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SFR_AW = 8;

    localparam logic [SFR_AW-1:0] CTRL_SFR   = 8'hB1;
    localparam logic [DATA_W-1:0] UNLOCK_KEY = 8'h5A;
    localparam logic [DATA_W-1:0] CTRL_RST   = 8'hA9;
    // 1 = bit stored, 0 = bit tied high
    localparam logic [DATA_W-1:0] CTRL_IMPL  = 8'h77;

    localparam int BIT_OFF = 0;
    localparam int BIT_VIS = 1;

    localparam logic [ADDR_W-1:0] WIN_LO = 16'hF700;
    localparam logic [ADDR_W-1:0] RAM_LO = 16'hF800;

    typedef enum logic [1:0] {
        TGT_EXT = 2'd0,
        TGT_RAM = 2'd1,
        TGT_PER = 2'd2
    } tgt_e;

    typedef struct packed {
        logic ram;
        logic per;
        logic iwe;
        logic rd;
        logic wr;
        logic aoe;
        logic doe;
    } route_t;

    function automatic logic [DATA_W-1:0] merge_ctrl(
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] wr,
        input logic              unlocked
    );
        logic [DATA_W-1:0] nxt;
        nxt = (wr & CTRL_IMPL) | ~CTRL_IMPL;
        nxt[BIT_OFF] = unlocked ? wr[BIT_OFF] : (cur[BIT_OFF] | wr[BIT_OFF]);
        return nxt;
    endfunction

endpackage

// File: rtl/xdr_ctrl_reg.sv
module xdr_ctrl_reg
    import xdr_pkg::*;
#(
    parameter logic [SFR_AW-1:0] REG_ADDR = CTRL_SFR,
    parameter logic [DATA_W-1:0] KEY      = UNLOCK_KEY,
    parameter logic [DATA_W-1:0] RST_VAL  = CTRL_RST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sfr_we,
    input  logic [SFR_AW-1:0] sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata,
    output logic              win_off,
    output logic              visible
);
    logic [DATA_W-1:0] ctrl_q;
    logic              armed_q;
    logic              hit_wr;
    logic              is_key;

    assign hit_wr = sfr_we && (sfr_addr == REG_ADDR);
    assign is_key = (sfr_wdata == KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= RST_VAL;
            armed_q <= 1'b0;
        end else begin
            armed_q <= hit_wr && is_key;
            if (hit_wr && !is_key)
                ctrl_q <= merge_ctrl(ctrl_q, sfr_wdata, armed_q);
        end
    end

    assign sfr_rdata = (sfr_addr == REG_ADDR) ? ctrl_q : '0;
    assign win_off   = ctrl_q[BIT_OFF];
    assign visible   = ctrl_q[BIT_VIS];
endmodule

// File: rtl/xdr_decode.sv
module xdr_decode
    import xdr_pkg::*;
#(
    parameter int                AW      = ADDR_W,
    parameter logic [AW-1:0]     WIN_BASE = WIN_LO,
    parameter logic [AW-1:0]     RAM_BASE = RAM_LO
) (
    input  logic [AW-1:0] addr,
    input  logic          win_on,
    output tgt_e          tgt
);
    always_comb begin
        if (!win_on || (addr < WIN_BASE))
            tgt = TGT_EXT;
        else if (addr >= RAM_BASE)
            tgt = TGT_RAM;
        else
            tgt = TGT_PER;
    end
endmodule

// File: rtl/xdr_steer.sv
module xdr_steer
    import xdr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          req,
    input  logic          we,
    input  tgt_e          tgt,
    input  logic          visible,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ram_rdata,
    input  logic [DW-1:0] per_rdata,
    input  logic [DW-1:0] ext_rdata,
    output route_t        route,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] dout
);
    logic          internal;
    logic          shown;
    logic [DW-1:0] int_rd;

    assign internal = (tgt != TGT_EXT);
    assign shown    = req && (!internal || visible);
    assign int_rd   = (tgt == TGT_RAM) ? ram_rdata : per_rdata;

    always_comb begin
        route.ram = req && (tgt == TGT_RAM);
        route.per = req && (tgt == TGT_PER);
        route.iwe = req && internal && we;
        route.rd  = shown && !we;
        route.wr  = shown && we;
        route.aoe = shown;
        route.doe = req && (internal ? visible : we);
    end

    assign rdata = internal ? int_rd : ext_rdata;
    assign dout  = we ? wdata : int_rd;
endmodule

// File: rtl/xdata_router.sv
module xdata_router
    import xdr_pkg::*;
#(
    parameter int                AW        = ADDR_W,
    parameter int                DW        = DATA_W,
    parameter logic [SFR_AW-1:0] REG_ADDR  = CTRL_SFR,
    parameter logic [DW-1:0]     KEY       = UNLOCK_KEY,
    parameter logic [AW-1:0]     WIN_BASE  = WIN_LO,
    parameter logic [AW-1:0]     RAM_BASE  = RAM_LO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_req,
    input  logic              acc_we,
    input  logic [AW-1:0]     acc_addr,
    input  logic [DW-1:0]     acc_wdata,
    output logic [DW-1:0]     acc_rdata,
    input  logic              sfr_we,
    input  logic [SFR_AW-1:0] sfr_addr,
    input  logic [DW-1:0]     sfr_wdata,
    output logic [DW-1:0]     sfr_rdata,
    input  logic [DW-1:0]     ram_rdata,
    input  logic [DW-1:0]     per_rdata,
    input  logic [DW-1:0]     ext_rdata,
    output logic              ram_sel,
    output logic              per_sel,
    output logic              int_we,
    output logic              ext_rd,
    output logic              ext_wr,
    output logic              port_addr_oe,
    output logic              port_data_oe,
    output logic [AW-1:0]     port_addr,
    output logic [DW-1:0]     port_dout
);
    logic   win_off;
    logic   visible;
    tgt_e   tgt;
    route_t route;

    xdr_ctrl_reg #(
        .REG_ADDR (REG_ADDR),
        .KEY      (KEY),
        .RST_VAL  (CTRL_RST)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sfr_we    (sfr_we),
        .sfr_addr  (sfr_addr),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .win_off   (win_off),
        .visible   (visible)
    );

    xdr_decode #(
        .AW       (AW),
        .WIN_BASE (WIN_BASE),
        .RAM_BASE (RAM_BASE)
    ) u_dec (
        .addr   (acc_addr),
        .win_on (!win_off),
        .tgt    (tgt)
    );

    xdr_steer #(
        .DW (DW)
    ) u_steer (
        .req       (acc_req),
        .we        (acc_we),
        .tgt       (tgt),
        .visible   (visible),
        .wdata     (acc_wdata),
        .ram_rdata (ram_rdata),
        .per_rdata (per_rdata),
        .ext_rdata (ext_rdata),
        .route     (route),
        .rdata     (acc_rdata),
        .dout      (port_dout)
    );

    assign ram_sel      = route.ram;
    assign per_sel      = route.per;
    assign int_we       = route.iwe;
    assign ext_rd       = route.rd;
    assign ext_wr       = route.wr;
    assign port_addr_oe = route.aoe;
    assign port_data_oe = route.doe;
    assign port_addr    = acc_addr;
endmodule

// File: rtl/xdr_checker.sv
module xdr_checker #(
    parameter int                AW       = 16,
    parameter logic [7:0]        REG_ADDR = 8'hB1,
    parameter logic [7:0]        KEY      = 8'h5A,
    parameter logic [AW-1:0]     WIN_BASE = 16'hF700
) (
    input logic          clk,
    input logic          rst,
    input logic          acc_req,
    input logic          acc_we,
    input logic [AW-1:0] acc_addr,
    input logic          sfr_we,
    input logic [7:0]    sfr_addr,
    input logic [7:0]    sfr_wdata,
    input logic [7:0]    sfr_rdata,
    input logic          ram_sel,
    input logic          per_sel,
    input logic          ext_rd,
    input logic          ext_wr,
    input logic          port_addr_oe,
    input logic          win_off,
    input logic          visible
);
    logic in_win;
    assign in_win = (acc_addr >= WIN_BASE);

    p_off_no_internal_r2: assert property (@(posedge clk) disable iff (rst)
        win_off |-> (!ram_sel && !per_sel));

    p_low_addr_external_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_req && !in_win) |-> (!ram_sel && !per_sel && port_addr_oe && (ext_rd != ext_wr)));

    p_hidden_strobes_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_req && in_win && !win_off && !visible) |-> (!ext_rd && !ext_wr && !port_addr_oe));

    p_trace_strobes_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_req && in_win && !win_off && visible) |-> ((ext_rd == !acc_we) && (ext_wr == acc_we)));

    p_clear_needs_key_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(win_off) |-> $past(sfr_we && (sfr_addr == REG_ADDR) && (sfr_wdata == KEY), 2));

    p_fixed_bits_r9: assert property (@(posedge clk) disable iff (rst)
        (sfr_addr == REG_ADDR) |-> (sfr_rdata[7] && sfr_rdata[3]));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(sfr_we && (sfr_addr == REG_ADDR)) |=> ($stable(win_off) && $stable(visible)));
endmodule

bind xdata_router xdr_checker #(
    .AW       (AW),
    .REG_ADDR (REG_ADDR),
    .KEY      (KEY),
    .WIN_BASE (WIN_BASE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_req      (acc_req),
    .acc_we       (acc_we),
    .acc_addr     (acc_addr),
    .sfr_we       (sfr_we),
    .sfr_addr     (sfr_addr),
    .sfr_wdata    (sfr_wdata),
    .sfr_rdata    (sfr_rdata),
    .ram_sel      (ram_sel),
    .per_sel      (per_sel),
    .ext_rd       (ext_rd),
    .ext_wr       (ext_wr),
    .port_addr_oe (port_addr_oe),
    .win_off      (win_off),
    .visible      (visible)
);

// File: tb/sim_xdata_router.sv
module sim_xdata_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_req = 1'b0;
    logic        acc_we = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic [7:0]  sfr_wdata = '0;
    logic [7:0]  sfr_rdata;
    logic [7:0]  ram_rdata, per_rdata, ext_rdata;
    logic        ram_sel, per_sel, int_we, ext_rd, ext_wr;
    logic        port_addr_oe, port_data_oe;
    logic [15:0] port_addr;
    logic [7:0]  port_dout;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] m_ctrl;
    bit         m_armed;

    always #5 clk = ~clk;

    assign ram_rdata = acc_addr[7:0] ^ 8'h3C;
    assign per_rdata = acc_addr[7:0] ^ 8'hC3;
    assign ext_rdata = acc_addr[15:8] ^ 8'h96;

    xdata_router u0 (
        .clk(clk), .rst(rst), .acc_req(acc_req), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .ram_rdata(ram_rdata), .per_rdata(per_rdata),
        .ext_rdata(ext_rdata), .ram_sel(ram_sel), .per_sel(per_sel),
        .int_we(int_we), .ext_rd(ext_rd), .ext_wr(ext_wr),
        .port_addr_oe(port_addr_oe), .port_data_oe(port_data_oe),
        .port_addr(port_addr), .port_dout(port_dout)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // SFR write, model updated from the requirement text (R7, R8, R9, R10)
    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        bit key;
        @(negedge clk);
        sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
        key = (a == 8'hB1) && (d == 8'h5A);
        if ((a == 8'hB1) && !key) begin
            logic [7:0] n;
            n = d | 8'h88;
            n[0] = m_armed ? d[0] : (m_ctrl[0] | d[0]);
            m_ctrl = n;
        end
        m_armed = key;
        @(posedge clk);
    endtask

    task automatic sfr_check(input logic [7:0] a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        sfr_we = 1'b0; sfr_addr = a; m_armed = 0;
        #1;
        e = (a == 8'hB1) ? m_ctrl : 8'h00;
        chk(sfr_rdata === e, tag, 64'(sfr_rdata), 64'(e));
    endtask

    task automatic access(input bit req, input bit we, input logic [15:0] a, input logic [7:0] wd);
        bit inr, shown;
        logic [7:0] e_rd, e_int;
        logic [6:0] e_v, a_v;
        string tag;
        @(negedge clk);
        acc_req = req; acc_we = we; acc_addr = a; acc_wdata = wd;
        #1;
        inr   = !m_ctrl[0] && (a >= 16'hF700);
        shown = req && (!inr || m_ctrl[1]);
        e_int = (a >= 16'hF800) ? (a[7:0] ^ 8'h3C) : (a[7:0] ^ 8'hC3);
        e_rd  = inr ? e_int : (a[15:8] ^ 8'h96);
        e_v = {req && inr && (a >= 16'hF800), req && inr && (a < 16'hF800),
               req && inr && we, shown && !we, shown && we, shown,
               req && (inr ? m_ctrl[1] : we)};
        a_v = {ram_sel, per_sel, int_we, ext_rd, ext_wr, port_addr_oe, port_data_oe};
        if (!req) tag = "R1 idle";
        else if (m_ctrl[0]) tag = "R2 window off";
        else if (a < 16'hF700) tag = "R3 low address";
        else if (!m_ctrl[1]) tag = "R4 R5 internal hidden";
        else tag = "R4 R6 internal traced";
        chk(a_v === e_v, tag, 64'(a_v), 64'(e_v));
        if (req) chk(acc_rdata === e_rd, tag, 64'(acc_rdata), 64'(e_rd));
        chk(port_addr === a, tag, 64'(port_addr), 64'(a));
        if (e_v[0]) begin
            logic [7:0] e_d;
            e_d = we ? wd : e_int;
            chk(port_dout === e_d, {tag, " dout"}, 64'(port_dout), 64'(e_d));
        end
    endtask

    task automatic sweep();
        for (int hi = 0; hi < 256; hi++) begin
            for (int w = 0; w < 2; w++) begin
                access(1'b1, w[0], {hi[7:0], hi[7:0] ^ 8'hA5}, hi[7:0] ^ 8'h5C);
            end
        end
        access(1'b0, 1'b0, 16'hF900, 8'h00);
        access(1'b0, 1'b1, 16'h1234, 8'h00);
    endtask

    initial begin
        m_ctrl = 8'hA9; m_armed = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        sfr_check(8'hB1, "R1 reset value");
        access(1'b0, 1'b0, 16'hF800, 8'h00);
        // R2/R3 sweep, window off, trace off
        sweep();
        // R10: foreign write between key and clear
        sfr_write(8'hB1, 8'h5A);
        sfr_write(8'hB2, 8'h00);
        sfr_write(8'hB1, 8'hA8);
        sfr_check(8'hB1, "R10 foreign write cancels key");
        sfr_check(8'hB2, "R9 other address reads zero");
        // R7: gap between key and clear
        sfr_write(8'hB1, 8'h5A);
        @(negedge clk); sfr_we = 1'b0; m_armed = 0;
        sfr_write(8'hB1, 8'h00);
        sfr_check(8'hB1, "R7 clear after gap blocked");
        // R9: fixed bits and storage bits
        sfr_write(8'hB1, 8'h76);
        sfr_check(8'hB1, "R9 storage bits");
        // window off, trace on: trace bit has no effect
        sfr_write(8'hB1, 8'hAB);
        sfr_check(8'hB1, "R2 trace while off");
        sweep();
        // R7: proper unlock, clear bit 0 and trace
        sfr_write(8'hB1, 8'h5A);
        sfr_write(8'hB1, 8'h00);
        sfr_check(8'hB1, "R7 unlocked clear");
        sweep();
        // trace on while enabled (bit 0 already 0)
        sfr_write(8'hB1, 8'h02);
        sfr_check(8'hB1, "R6 trace on");
        sweep();
        // R8: set without key
        sfr_write(8'hB1, 8'h01);
        sfr_check(8'hB1, "R8 set without key");
        access(1'b1, 1'b0, 16'hFC00, 8'h00);
        access(1'b1, 1'b1, 16'hF7FF, 8'h11);
        // R7: key then key then clear: second key rearms
        sfr_write(8'hB1, 8'h5A);
        sfr_write(8'hB1, 8'h5A);
        sfr_write(8'hB1, 8'h20);
        sfr_check(8'hB1, "R7 double key");
        access(1'b1, 1'b0, 16'hF700, 8'h00);
        access(1'b1, 1'b1, 16'hF6FF, 8'h33);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule